// File: doc/BRIEF.md
# Soft-Value Block Buffer and Decoder Sequencer

This block sits in front of a parallel decoder core that settles in continuous time. It gathers a stream of signed soft values, each one a measure of how likely a received code bit is a one rather than a zero. The values fill a buffer exactly one code block long: 14 trellis steps of a rate-1/2 code, which is 28 soft values. Each value is turned into an offset-binary DAC code on arrival. A normal mode gives 3-bit codes and a test mode gives 6-bit codes, and both saturate to their range.

Once a block is complete, the sequencer presents all 28 codes at once on a parallel bus and raises an enable. It holds them for a programmable settle time, then samples the core's 14 parallel hard decisions. It shifts those decisions out as a serial bitstream with a valid flag. The buffer has two banks, so the next block can arrive while the current one settles and drains. A value that finds both banks occupied is dropped, and a sticky error flag is raised.

Top module: `soft_blk_seq`

## Requirements
- R1: While rst_ni is low and after its release, before any input, dac_code_o is 0 and dac_en_o, bit_valid_o, bit_o and overrun_o are 0.
- R2: Each group of 28 accepted soft values forms one block. The k-th accepted value of a block (k from 0) appears on dac_code_o bits [6k+5:6k] while dac_en_o is high.
- R3: With test_mode_i low when a value is accepted, the value is clipped to [-4, 3] and offset by +4, giving a code 0..7 whose three upper bits are 0.
- R4: With test_mode_i high when a value is accepted, the value is clipped to [-32, 31] and offset by +32, giving a code 0..63.
- R5: For each block, dac_en_o is high for max(S,1)+1 consecutive cycles, where S is settle_i. dac_code_o is constant throughout that window.
- R6: dec_bits_i is sampled in the last cycle of the dac_en_o window. Values presented earlier in the window have no effect on the output.
- R7: In the cycle after dac_en_o falls, bit_valid_o rises and stays high for exactly 14 cycles. bit_o carries decision bit 0 first, then bits 1 to 13 in order, and bit_o is 0 whenever bit_valid_o is low.
- R8: Blocks are accepted while an earlier block is settling or shifting out. They are processed and emitted in arrival order without loss, provided no more than two blocks are pending.
- R9: A soft value that arrives while both banks hold unprocessed blocks is discarded and sets overrun_o. overrun_o stays high until reset, and a discarded block produces no output.
- R10: soft_i has no effect while soft_valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_i | input | 8 | Signed two's-complement soft value |
| soft_valid_i | input | 1 | soft_i is valid this cycle |
| test_mode_i | input | 1 | 1 selects 6-bit codes, 0 selects 3-bit codes |
| settle_i | input | 10 | Settle time in cycles (0 treated as 1) |
| dac_code_o | output | 168 | 28 DAC codes of 6 bits, element k at [6k+5:6k] |
| dac_en_o | output | 1 | Load/enable for the decoder core |
| dec_bits_i | input | 14 | Parallel hard decisions from the core |
| bit_o | output | 1 | Serial decoded bit |
| bit_valid_o | output | 1 | bit_o is valid |
| overrun_o | output | 1 | Sticky buffer overrun flag |

## Verification
The last value of a block is registered at one edge. dac_en_o rises two edges later if the sequencer is idle, and later still if a block is already in progress. For that reason the bench does not count latency from the input side. It checks all codes in the first cycle of dac_en_o and the window length at its falling edge, and it collects the serial bits during the 14 cycles that follow. The behavioural core model returns inverted decisions until it has been enabled for settle_i edges, so a capture taken even one cycle early shows up as wrong bits. All sampling happens on the falling clock edge, half a cycle after the register updates.

// File: rtl/soft_blk_pkg.sv
package soft_blk_pkg;
  typedef enum logic [2:0] {
    ST_COLLECT,
    ST_APPLY,
    ST_SETTLE,
    ST_CAPTURE,
    ST_SHIFT
  } seq_state_e;
endpackage

// File: rtl/soft_blk_conv.sv
module soft_blk_conv #(
  parameter int SOFT_W = 8,
  parameter int CODE_W = 6,
  parameter int NORM_W = 3
) (
  input  logic signed [SOFT_W-1:0] soft_i,
  input  logic                     test_mode_i,
  output logic [CODE_W-1:0]        code_o
);
  localparam int WIDE_HI = 2**(CODE_W-1) - 1;
  localparam int WIDE_LO = -(2**(CODE_W-1));
  localparam int NORM_HI = 2**(NORM_W-1) - 1;
  localparam int NORM_LO = -(2**(NORM_W-1));

  logic signed [SOFT_W-1:0] hi_s, lo_s, clip_s;
  logic [SOFT_W-1:0]        off_u, sum_u;

  always_comb begin
    hi_s   = test_mode_i ? SOFT_W'(WIDE_HI) : SOFT_W'(NORM_HI);
    lo_s   = test_mode_i ? SOFT_W'(WIDE_LO) : SOFT_W'(NORM_LO);
    off_u  = test_mode_i ? SOFT_W'(-WIDE_LO) : SOFT_W'(-NORM_LO);
    if (soft_i > hi_s)      clip_s = hi_s;
    else if (soft_i < lo_s) clip_s = lo_s;
    else                    clip_s = soft_i;
    sum_u  = $unsigned(clip_s) + off_u;
    code_o = sum_u[CODE_W-1:0];
  end
endmodule

// File: rtl/soft_blk_bank.sv
module soft_blk_bank #(
  parameter int N_SOFT = 28,
  parameter int CODE_W = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [CODE_W-1:0]          code_i,
  input  logic                       valid_i,
  input  logic                       take_i,
  output logic                       ready_o,
  output logic [N_SOFT*CODE_W-1:0]   block_o,
  output logic                       overrun_o
);
  localparam int CNT_W = $clog2(N_SOFT);

  logic [CODE_W-1:0] mem_q [2][N_SOFT];
  logic [CNT_W-1:0]  wr_cnt_q;
  logic              wr_sel_q, rd_sel_q, ovr_q;
  logic [1:0]        full_q, full_d;
  logic              wr_ok, wr_last;

  assign wr_ok   = valid_i && !full_q[wr_sel_q];
  assign wr_last = (wr_cnt_q == CNT_W'(N_SOFT-1));

  always_comb begin
    full_d = full_q;
    if (take_i)           full_d[rd_sel_q] = 1'b0;
    if (wr_ok && wr_last) full_d[wr_sel_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q   <= '0;
      wr_cnt_q <= '0;
      wr_sel_q <= 1'b0;
      rd_sel_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      full_q <= full_d;
      if (take_i) rd_sel_q <= ~rd_sel_q;
      if (valid_i && full_q[wr_sel_q]) ovr_q <= 1'b1;
      if (wr_ok) begin
        if (wr_last) begin
          wr_cnt_q <= '0;
          wr_sel_q <= ~wr_sel_q;
        end else begin
          wr_cnt_q <= wr_cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // storage needs no reset: contents are only read once a bank is full
  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_sel_q][wr_cnt_q] <= code_i;
  end

  for (genvar k = 0; k < N_SOFT; k++) begin : g_flat
    assign block_o[k*CODE_W +: CODE_W] = mem_q[rd_sel_q][k];
  end

  assign ready_o   = full_q[rd_sel_q];
  assign overrun_o = ovr_q;
endmodule

// File: rtl/soft_blk_fsm.sv
module soft_blk_fsm
  import soft_blk_pkg::*;
#(
  parameter int N_SOFT = 28,
  parameter int N_BITS = 14,
  parameter int CODE_W = 6,
  parameter int SET_W  = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ready_i,
  input  logic [N_SOFT*CODE_W-1:0] block_i,
  input  logic [SET_W-1:0]         settle_i,
  input  logic [N_BITS-1:0]        dec_bits_i,
  output logic                     take_o,
  output logic [N_SOFT*CODE_W-1:0] dac_code_o,
  output logic                     dac_en_o,
  output logic                     bit_o,
  output logic                     bit_valid_o
);
  localparam int IDX_W = $clog2(N_BITS);

  seq_state_e               state_q;
  logic [SET_W-1:0]         cnt_q;
  logic [IDX_W-1:0]         idx_q;
  logic [N_BITS-1:0]        cap_q;
  logic [N_SOFT*CODE_W-1:0] dac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_COLLECT;
      cnt_q   <= '0;
      idx_q   <= '0;
      cap_q   <= '0;
      dac_q   <= '0;
    end else begin
      unique case (state_q)
        ST_COLLECT: if (ready_i) state_q <= ST_APPLY;
        ST_APPLY: begin
          dac_q   <= block_i;  // copy frees the bank for the next block
          cnt_q   <= settle_i;
          state_q <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (cnt_q <= SET_W'(1)) state_q <= ST_CAPTURE;
          else                    cnt_q   <= cnt_q - SET_W'(1);
        end
        ST_CAPTURE: begin
          cap_q   <= dec_bits_i;
          idx_q   <= '0;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (idx_q == IDX_W'(N_BITS-1)) state_q <= ST_COLLECT;
          else                           idx_q   <= idx_q + IDX_W'(1);
        end
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

  assign take_o      = (state_q == ST_APPLY);
  assign dac_code_o  = dac_q;
  assign dac_en_o    = (state_q == ST_SETTLE) || (state_q == ST_CAPTURE);
  assign bit_valid_o = (state_q == ST_SHIFT);
  assign bit_o       = bit_valid_o & cap_q[idx_q];
endmodule

// File: rtl/soft_blk_seq.sv
module soft_blk_seq #(
  parameter int SOFT_W = 8,
  parameter int N_BITS = 14,
  parameter int CODE_W = 6,
  parameter int NORM_W = 3,
  parameter int SET_W  = 10,
  localparam int N_SOFT = 2 * N_BITS
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [SOFT_W-1:0] soft_i,
  input  logic                     soft_valid_i,
  input  logic                     test_mode_i,
  input  logic [SET_W-1:0]         settle_i,
  output logic [N_SOFT*CODE_W-1:0] dac_code_o,
  output logic                     dac_en_o,
  input  logic [N_BITS-1:0]        dec_bits_i,
  output logic                     bit_o,
  output logic                     bit_valid_o,
  output logic                     overrun_o
);
  logic [CODE_W-1:0]        code_w;
  logic                     ready_w, take_w;
  logic [N_SOFT*CODE_W-1:0] block_w;

  soft_blk_conv #(.SOFT_W(SOFT_W), .CODE_W(CODE_W), .NORM_W(NORM_W)) u_conv (
    .soft_i      (soft_i),
    .test_mode_i (test_mode_i),
    .code_o      (code_w)
  );

  soft_blk_bank #(.N_SOFT(N_SOFT), .CODE_W(CODE_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_i    (code_w),
    .valid_i   (soft_valid_i),
    .take_i    (take_w),
    .ready_o   (ready_w),
    .block_o   (block_w),
    .overrun_o (overrun_o)
  );

  soft_blk_fsm #(.N_SOFT(N_SOFT), .N_BITS(N_BITS), .CODE_W(CODE_W), .SET_W(SET_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ready_i     (ready_w),
    .block_i     (block_w),
    .settle_i    (settle_i),
    .dec_bits_i  (dec_bits_i),
    .take_o      (take_w),
    .dac_code_o  (dac_code_o),
    .dac_en_o    (dac_en_o),
    .bit_o       (bit_o),
    .bit_valid_o (bit_valid_o)
  );
endmodule

// File: rtl/soft_blk_seq_chk.sv
module soft_blk_seq_chk #(
  parameter int N_BITS = 14,
  parameter int CODE_W = 6,
  localparam int N_SOFT = 2 * N_BITS
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [N_SOFT*CODE_W-1:0] dac_code_o,
  input logic                     dac_en_o,
  input logic                     bit_o,
  input logic                     bit_valid_o,
  input logic                     overrun_o
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= 0;
    else if (bit_valid_o) run_q <= run_q + 1;
    else                  run_q <= 0;
  end

  AST_CODES_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_en_o && $past(dac_en_o) |-> $stable(dac_code_o)); // R5
  AST_CAPTURE_THEN_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bit_valid_o) |-> $past(dac_en_o)); // R6
  AST_SHIFT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dac_en_o) |-> bit_valid_o); // R7
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dac_en_o && bit_valid_o)); // R7
  AST_BIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_o |-> !bit_o); // R7
  AST_SHIFT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> run_q < N_BITS); // R7
  AST_SHIFT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bit_valid_o) |-> run_q == N_BITS); // R7
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o); // R9
endmodule

bind soft_blk_seq soft_blk_seq_chk #(.N_BITS(N_BITS), .CODE_W(CODE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dac_code_o  (dac_code_o),
  .dac_en_o    (dac_en_o),
  .bit_o       (bit_o),
  .bit_valid_o (bit_valid_o),
  .overrun_o   (overrun_o)
);

// File: tb/soft_blk_seq_bench.sv
module soft_blk_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 14;
  localparam int NS = 28;
  localparam int CW = 6;
  localparam int MAXB = 48;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic signed [7:0] soft_i = '0;
  logic              soft_valid_i = 1'b0;
  logic              test_mode_i = 1'b0;
  logic [9:0]        settle_i = 10'd5;
  logic [NS*CW-1:0]  dac_code_o;
  logic              dac_en_o;
  logic [NB-1:0]     dec_bits;
  logic              bit_o, bit_valid_o, overrun_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_soft [MAXB][NS];
  bit exp_mode [MAXB];
  int n_fed = 0, n_apply = 0, n_out = 0;
  int en_len = 0, nb = 0, en_cnt = 0;
  bit en_prev = 1'b0;
  logic [NB-1:0] got_bits;

  always #(CLK_PERIOD/2) clk = ~clk;

  soft_blk_seq u_soft_blk_seq (
    .clk_i (clk), .rst_ni (rst_n), .soft_i (soft_i), .soft_valid_i (soft_valid_i),
    .test_mode_i (test_mode_i), .settle_i (settle_i), .dac_code_o (dac_code_o),
    .dac_en_o (dac_en_o), .dec_bits_i (dec_bits), .bit_o (bit_o),
    .bit_valid_o (bit_valid_o), .overrun_o (overrun_o)
  );

  // core model: correct decisions only after settle_i enabled edges
  always @(posedge clk) begin
    if (!dac_en_o) en_cnt <= 0;
    else           en_cnt <= en_cnt + 1;
  end
  always_comb begin
    for (int i = 0; i < NB; i++) begin
      dec_bits[i] = (dac_code_o[2*i*CW +: CW] > dac_code_o[(2*i+1)*CW +: CW]);
      if (!(dac_en_o && en_cnt >= int'(settle_i))) dec_bits[i] = ~dec_bits[i];
    end
  end

  function automatic int exp_code(int s, bit m);
    int lo, hi;
    lo = m ? -32 : -4;
    hi = m ? 31 : 3;
    if (s > hi) s = hi;
    if (s < lo) s = lo;
    return s - lo;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      en_prev = 1'b0; en_len = 0; nb = 0;
    end else begin
      if (dac_en_o && !en_prev) begin
        int bad_k, act, expv;
        bad_k = -1; act = 0; expv = 0;
        for (int k = 0; k < NS; k++) begin
          int e;
          e = exp_code(exp_soft[n_apply % MAXB][k], exp_mode[n_apply % MAXB]);
          if (bad_k < 0 && int'(dac_code_o[k*CW +: CW]) != e) begin
            bad_k = k; act = int'(dac_code_o[k*CW +: CW]); expv = e;
          end
        end
        // R2 element order, R3 normal codes, R4 test codes
        check(bad_k < 0, exp_mode[n_apply % MAXB] ? "R2 R4 codes" : "R2 R3 codes", act, expv);
        en_len = 1;
      end else if (dac_en_o) begin
        en_len++;
      end else if (en_prev) begin
        int want;
        want = (settle_i == 0 ? 1 : int'(settle_i)) + 1;
        check(en_len == want, "R5 enable window", en_len, want);
        check(bit_valid_o == 1'b1, "R7 shift start", int'(bit_valid_o), 1);
        n_apply++;
      end
      if (bit_valid_o) begin
        got_bits[nb] = bit_o;
        nb++;
        if (nb == NB) begin
          logic [NB-1:0] e;
          for (int i = 0; i < NB; i++)
            e[i] = exp_code(exp_soft[n_out % MAXB][2*i], exp_mode[n_out % MAXB]) >
                   exp_code(exp_soft[n_out % MAXB][2*i+1], exp_mode[n_out % MAXB]);
          check(got_bits == e, "R6 R7 R8 serial bits", int'(got_bits), int'(e));
          n_out++;
          nb = 0;
        end
      end else if (nb != 0) begin
        check(1'b0, "R7 shift length", nb, NB);
        nb = 0;
      end
      en_prev = dac_en_o;
    end
  end

  task automatic feed_block(int base, int step, bit mode, int gap, bit store);
    for (int k = 0; k < NS; k++) begin
      int v;
      v = ((base + k*step) % 256) - 128;
      if (store) exp_soft[n_fed % MAXB][k] = v;
      @(negedge clk);
      soft_valid_i = 1'b1;
      test_mode_i  = mode;
      soft_i       = 8'(v);
      if (gap > 0) begin
        @(negedge clk);
        soft_valid_i = 1'b0;
        repeat (gap-1) @(negedge clk);
      end
    end
    if (store) begin
      exp_mode[n_fed % MAXB] = mode;
      n_fed++;
    end
    @(negedge clk);
    soft_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    while (n_out != n_fed && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(n_out == n_fed, "R8 blocks drained", n_out, n_fed);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during and after reset
    check(dac_en_o == 1'b0 && bit_valid_o == 1'b0, "R1 reset controls", int'(dac_en_o), 0);
    check(dac_code_o == '0, "R1 reset codes", int'(dac_code_o[31:0]), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(overrun_o == 1'b0, "R1 overrun clear", int'(overrun_o), 0);
    check(bit_o == 1'b0 && bit_valid_o == 1'b0, "R1 serial idle", int'(bit_o), 0);

    // R3 sweep: all 256 input values, normal mode
    settle_i = 10'd5;
    for (int b = 0; b < 10; b++) begin
      feed_block(b*28, 1, 1'b0, 1, 1'b1);
      wait_idle();
    end
    // R4 sweep: test mode, minimum settle (R5 S=0)
    settle_i = 10'd0;
    for (int b = 0; b < 10; b++) begin
      feed_block(b*28 + 3, 1, 1'b1, 1, 1'b1);
      wait_idle();
    end
    settle_i = 10'd1;
    feed_block(120, 7, 1'b0, 2, 1'b1);
    feed_block(5, 37, 1'b1, 0, 1'b1);
    wait_idle();

    // R8: three blocks back to back while earlier ones settle
    settle_i = 10'd40;
    feed_block(17, 3, 1'b1, 0, 1'b1);
    feed_block(90, 11, 1'b0, 0, 1'b1);
    feed_block(200, 5, 1'b1, 0, 1'b1);
    wait_idle();
    check(overrun_o == 1'b0, "R8 no overrun", int'(overrun_o), 0);

    // R10: soft_i toggles with valid low
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      soft_i = 8'(i * 37);
      test_mode_i = i[0];
    end
    repeat (10) @(negedge clk);
    check(n_apply == n_fed, "R10 ignored input", n_apply, n_fed);
    feed_block(60, 13, 1'b0, 0, 1'b1);
    wait_idle();

    // R9: fourth back-to-back block finds both banks full
    settle_i = 10'd300;
    feed_block(10, 9, 1'b1, 0, 1'b1);
    feed_block(33, 4, 1'b0, 0, 1'b1);
    feed_block(77, 6, 1'b1, 0, 1'b1);
    feed_block(150, 2, 1'b0, 0, 1'b0);
    check(overrun_o == 1'b1, "R9 overrun set", int'(overrun_o), 1);
    wait_idle();
    repeat (60) @(negedge clk);
    check(n_apply == n_fed, "R9 dropped block silent", n_apply, n_fed);
    check(overrun_o == 1'b1, "R9 overrun sticky", int'(overrun_o), 1);

    rst_n = 1'b0;
    @(negedge clk);
    check(overrun_o == 1'b0 && dac_en_o == 1'b0, "R1 reset clears overrun", int'(overrun_o), 0);
    finish_run();
  end
endmodule